// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multi-register load or store. A request names a base address, a mask choosing any subset of sixteen registers, an addressing mode, a load/store flag and a writeback flag. The sequencer then issues one memory transfer per cycle, each carrying a word address and the index of the register it belongs to. Registers are always visited from the lowest index upward, paired with addresses that climb by one word. For decrementing modes the lowest address is computed first, so the walk runs upward there as well.

A request may also be phrased in stack terms: full or empty, ascending or descending. A fixed table turns each of these into one of the four addressing modes. The table gives a different mode for a pop (load) than for a push (store), so that a push and the matching pop meet the same words.

Once accepted, a sequence runs to completion. Transfers wait on a memory ready signal, and the current transfer is held steady while it waits. One cycle after the last transfer the block raises a done pulse. With that pulse it presents the updated base and a write-enable for it. The register file and the memory sit outside the block.

Top module: `bxfer_seq`

## Requirements
- R1: Mode code 0 (increment-after): the first transfer goes to the base and each later one to the next word up (+4).
- R2: Mode code 1 (increment-before): the first transfer goes to base+4, so the word at the base is never touched, and later ones step +4.
- R3: Mode code 2 (decrement-after): the first transfer goes to base-4N+4, where N is the number of set mask bits, and later ones step +4.
- R4: Mode code 3 (decrement-before): the first transfer goes to base-4N, and later ones step +4.
- R5: Exactly N transfers are issued. Their register indices are the set mask bits in ascending order, and the lowest index is paired with the lowest address.
- R6: On the done cycle, wb_en equals the writeback flag when N>0, and wb_value is base+4N for the increment modes or base-4N for the decrement modes.
- R7: done is a single-cycle pulse one cycle after the last accepted transfer. An all-zero mask gives done one cycle after acceptance, with no transfers and wb_en low.
- R8: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_reg and mem_load hold their values.
- R9: When req_stack is 1, req_mode is read as {empty, ascending} (bit1=1 empty, bit0=1 ascending). Loads map full-asc→2, full-desc→0, empty-asc→3, empty-desc→1. Stores map full-asc→1, full-desc→3, empty-asc→0, empty-desc→2.
- R10: req_ready is high only when the block is idle. A req_valid raised during a sequence is ignored and does not change that sequence's addresses, indices or result.
- R11: mem_load carries the request's load flag (1 = load) on every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_base | input | ADDR_W | Base address |
| req_mask | input | NREG | Register-select mask |
| req_mode | input | 2 | Addressing mode code, or stack kind when req_stack=1 |
| req_stack | input | 1 | Interpret req_mode as a stack kind |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Write the updated base back |
| mem_valid | output | 1 | Transfer present |
| mem_ready | input | 1 | Memory accepts the transfer |
| mem_addr | output | ADDR_W | Word address of the transfer |
| mem_reg | output | clog2(NREG) | Register index of the transfer |
| mem_load | output | 1 | Direction of the transfer |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| wb_en | output | 1 | Write enable for the updated base |
| wb_value | output | ADDR_W | Updated base value |

## Verification
The first transfer appears one clock after the edge that accepts the request. Each later transfer appears one clock after an edge on which mem_ready was high. done, wb_en and wb_value are due one clock after the edge that takes the last transfer, or one clock after acceptance when the mask is empty. The bench drives every input on the falling edge and checks the outputs on that same falling edge before changing anything, so each value is read half a period after the register that produced it settled. Stall cycles get a second check one clock later to confirm the held transfer did not move.

// File: rtl/bxfer_pkg.sv
package bxfer_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        addr_mode_e mode;
        logic       is_load;
        logic       wb;
    } xfer_cmd_t;

    // Stack kind to addressing mode. A pop undoes the matching push.
    function automatic addr_mode_e stack_to_mode(input logic is_load,
                                                 input logic empty_kind,
                                                 input logic ascending);
        addr_mode_e m;
        case ({is_load, empty_kind, ascending})
            3'b101:  m = AM_DEC_AFTER;   // pop, full ascending
            3'b100:  m = AM_INC_AFTER;   // pop, full descending
            3'b111:  m = AM_DEC_BEFORE;  // pop, empty ascending
            3'b110:  m = AM_INC_BEFORE;  // pop, empty descending
            3'b001:  m = AM_INC_BEFORE;  // push, full ascending
            3'b000:  m = AM_DEC_BEFORE;  // push, full descending
            3'b011:  m = AM_INC_AFTER;   // push, empty ascending
            default: m = AM_DEC_AFTER;   // push, empty descending
        endcase
        return m;
    endfunction

    function automatic logic mode_is_down(input addr_mode_e m);
        return (m == AM_DEC_AFTER) || (m == AM_DEC_BEFORE);
    endfunction

endpackage

// File: rtl/bxfer_mode_decode.sv
module bxfer_mode_decode
    import bxfer_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic       use_stack,
    input  logic       is_load,
    input  logic       wb,
    output xfer_cmd_t  cmd
);
    always_comb begin
        cmd.is_load = is_load;
        cmd.wb      = wb;
        if (use_stack)
            cmd.mode = stack_to_mode(is_load, mode_field[1], mode_field[0]);
        else
            cmd.mode = addr_mode_e'(mode_field);
    end
endmodule

// File: rtl/bxfer_addr_plan.sv
module bxfer_addr_plan
    import bxfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   mask,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] final_base
);
    localparam int CNT_W      = $clog2(NREG + 1);
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_addr;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++)
            count = count + CNT_W'(mask[i]);
    end

    assign span     = ADDR_W'(count) << WORD_SHIFT;
    assign low_addr = base - span;

    always_comb begin
        unique case (mode)
            AM_INC_AFTER:  start_addr = base;
            AM_INC_BEFORE: start_addr = base + STEP;
            AM_DEC_AFTER:  start_addr = low_addr + STEP;
            default:       start_addr = low_addr;
        endcase
        final_base = mode_is_down(mode) ? low_addr : base + span;
    end
endmodule

// File: rtl/bxfer_mask_walk.sv
module bxfer_mask_walk #(
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic [NREG-1:0]         load_mask,
    input  logic                    step,
    output logic [$clog2(NREG)-1:0] idx,
    output logic                    last
);
    localparam int IDX_W = $clog2(NREG);

    logic [NREG-1:0] rem_q;
    logic [NREG-1:0] rem_drop;

    assign rem_drop = rem_q & (rem_q - NREG'(1));

    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--)
            if (rem_q[i]) idx = IDX_W'(i);
    end

    assign last = (rem_q != '0) && (rem_drop == '0);

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (load_en)
            rem_q <= load_mask;
        else if (step)
            rem_q <= rem_drop;
    end
endmodule

// File: rtl/bxfer_seq.sv
module bxfer_seq
    import bxfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_base,
    input  logic [NREG-1:0]         req_mask,
    input  logic [1:0]              req_mode,
    input  logic                    req_stack,
    input  logic                    req_load,
    input  logic                    req_wb,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [$clog2(NREG)-1:0] mem_reg,
    output logic                    mem_load,
    output logic                    done,
    output logic                    wb_en,
    output logic [ADDR_W-1:0]       wb_value
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    seq_state_e        state_q;
    xfer_cmd_t         cmd;
    logic [ADDR_W-1:0] plan_start;
    logic [ADDR_W-1:0] plan_final;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] final_q;
    logic              load_q;
    logic              wb_q;
    logic              accept;
    logic              step;
    logic              walk_last;
    logic              mask_empty;

    assign accept     = req_valid && (state_q == SQ_IDLE);
    assign step       = (state_q == SQ_XFER) && mem_ready;
    assign mask_empty = (req_mask == '0);

    bxfer_mode_decode u_decode (
        .mode_field (req_mode),
        .use_stack  (req_stack),
        .is_load    (req_load),
        .wb         (req_wb),
        .cmd        (cmd)
    );

    bxfer_addr_plan #(
        .NREG       (NREG),
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_plan (
        .base       (req_base),
        .mask       (req_mask),
        .mode       (cmd.mode),
        .start_addr (plan_start),
        .final_base (plan_final)
    );

    bxfer_mask_walk #(
        .NREG (NREG)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load_en   (accept),
        .load_mask (req_mask),
        .step      (step),
        .idx       (mem_reg),
        .last      (walk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            final_q <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        addr_q  <= plan_start;
                        final_q <= plan_final;
                        load_q  <= cmd.is_load;
                        wb_q    <= cmd.wb && !mask_empty;
                        state_q <= mask_empty ? SQ_FIN : SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (step) begin
                        if (walk_last)
                            state_q <= SQ_FIN;
                        else
                            addr_q <= addr_q + STEP;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == SQ_IDLE);
    assign mem_valid = (state_q == SQ_XFER);
    assign mem_addr  = addr_q;
    assign mem_load  = load_q;
    assign done      = (state_q == SQ_FIN);
    assign wb_en     = (state_q == SQ_FIN) && wb_q;
    assign wb_value  = final_q;
endmodule

// File: rtl/bxfer_seq_chk.sv
module bxfer_seq_chk #(
    parameter int NREG       = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [NREG-1:0]         req_mask,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [$clog2(NREG)-1:0] mem_reg,
    input logic                    mem_load,
    input logic                    done,
    input logic                    wb_en
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_reg) && $stable(mem_load));

    a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
        mem_valid && $past(mem_valid && mem_ready) |-> mem_addr == $past(mem_addr) + STEP);

    a_r5_reg_ascend: assert property (@(posedge clk) disable iff (rst)
        mem_valid && $past(mem_valid && mem_ready) |-> mem_reg > $past(mem_reg));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_valid || done) |-> !req_ready);

    a_r6_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_empty_mask: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_mask == '0) |=> done && !mem_valid && !wb_en);
endmodule

bind bxfer_seq bxfer_seq_chk #(
    .NREG       (NREG),
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_reg   (mem_reg),
    .mem_load  (mem_load),
    .done      (done),
    .wb_en     (wb_en)
);

// File: tb/bxfer_seq_bench.sv
module bxfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [31:0] req_base;
    logic [15:0] req_mask;
    logic [1:0]  req_mode;
    logic        req_stack, req_load, req_wb;
    logic        mem_valid, mem_ready, mem_load;
    logic [31:0] mem_addr;
    logic [3:0]  mem_reg;
    logic        done, wb_en;
    logic [31:0] wb_value;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bxfer_seq u_bxfer_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_mask(req_mask), .req_mode(req_mode),
        .req_stack(req_stack), .req_load(req_load), .req_wb(req_wb),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_reg(mem_reg), .mem_load(mem_load),
        .done(done), .wb_en(wb_en), .wb_value(wb_value)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R9 table: key {load, empty, ascending}
    function automatic logic [1:0] stack_mode(input logic [1:0] kind, input bit ld);
        case ({ld, kind})
            3'b101: return 2'd2;
            3'b100: return 2'd0;
            3'b111: return 2'd3;
            3'b110: return 2'd1;
            3'b001: return 2'd1;
            3'b000: return 2'd3;
            3'b011: return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

    task automatic run_req(input logic [31:0] base, input logic [15:0] mask,
                           input logic [1:0] field, input bit stk, input bit ld,
                           input bit wb, input int seed);
        int n;
        int i;
        logic [1:0]  em;
        logic [31:0] start, fin;
        string mtag;
        n  = $countones(mask);
        em = stk ? stack_mode(field, ld) : field;
        case (em)
            2'd0: start = base;
            2'd1: start = base + 32'd4;
            2'd2: start = base - 32'(4 * n) + 32'd4;
            default: start = base - 32'(4 * n);
        endcase
        fin = em[1] ? base - 32'(4 * n) : base + 32'(4 * n);
        if (stk) mtag = "R9";
        else if (em == 2'd0) mtag = "R1";
        else if (em == 2'd1) mtag = "R2";
        else if (em == 2'd2) mtag = "R3";
        else mtag = "R4";

        @(negedge clk);
        check_eq("R10 idle ready", 32'(req_ready), 32'd1);
        req_base = base; req_mask = mask; req_mode = field;
        req_stack = stk; req_load = ld; req_wb = wb;
        req_valid = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        req_base = 32'hDEAD_BEEC; req_mask = 16'hFFFF; req_mode = ~field;
        i = 0;
        for (int r = 0; r < 16; r++) begin
            if (mask[r]) begin
                check_eq({mtag, " valid"}, 32'(mem_valid), 32'd1);
                check_eq({mtag, " addr"}, mem_addr, start + 32'(4 * i));
                check_eq("R5 reg index", 32'(mem_reg), 32'(r));
                check_eq("R11 direction", 32'(mem_load), 32'(ld));
                if ((i + seed) % 3 == 0) begin
                    mem_ready = 1'b0;
                    req_valid = 1'b1;
                    @(negedge clk);
                    check_eq("R8 hold valid", 32'(mem_valid), 32'd1);
                    check_eq("R8 hold addr", mem_addr, start + 32'(4 * i));
                    check_eq("R8 hold reg", 32'(mem_reg), 32'(r));
                    check_eq("R10 busy ready", 32'(req_ready), 32'd0);
                    req_valid = 1'b0;
                end
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
                i++;
            end
        end
        check_eq("R7 done", 32'(done), 32'd1);
        check_eq("R5 no extra transfer", 32'(mem_valid), 32'd0);
        check_eq("R6 wb_en", 32'(wb_en), 32'(wb && n != 0));
        if (n == 0) check_eq("R7 empty wb_en", 32'(wb_en), 32'd0);
        if (wb && n != 0) check_eq("R6 wb_value", wb_value, fin);
        @(negedge clk);
        check_eq("R7 done pulse", 32'(done), 32'd0);
    endtask

    localparam logic [15:0] MASKS [8] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF,
                                          16'h0A5C, 16'h4002, 16'h3C91, 16'hB6E4};

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_base = '0; req_mask = '0; req_mode = '0;
        req_stack = 1'b0; req_load = 1'b0; req_wb = 1'b0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_eq("R10 reset ready", 32'(req_ready), 32'd1);
        check_eq("R5 reset valid", 32'(mem_valid), 32'd0);
        check_eq("R7 reset done", 32'(done), 32'd0);
        check_eq("R6 reset wb_en", 32'(wb_en), 32'd0);
        for (int m = 0; m < 8; m++)
            for (int stk = 0; stk < 2; stk++)
                for (int f = 0; f < 4; f++)
                    for (int ld = 0; ld < 2; ld++)
                        for (int wb = 0; wb < 2; wb++)
                            run_req((m % 2 == 0) ? 32'h0008_0010 : 32'h0000_0004,
                                    MASKS[m], 2'(f), stk[0], ld[0], wb[0], m + f);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule